// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Read Timing and Programmable Threshold Flags

This block is an 18-bit-wide first-in first-out buffer. Its depth is a parameter: 256, 512, 1024, 2048 or 4096 words. Writes are timed by one clock and reads by another. The two clocks may be the same net or be fully unrelated. Pointers are exchanged between the two clock domains as Gray codes through two-flop synchronisers. Each domain then computes its own fill count from its local pointer and the synchronised pointer of the other side.

A mode input is captured while reset is held and stays fixed until the next reset.

- **Standard mode:** every word reaches the output register only on a read-enabled read-clock edge. The two status outputs mean "empty" and "full".
- **Fall-through mode:** the oldest stored word moves to the output register on its own. The read enable then acts as an acknowledge that fetches the next word. The status outputs change meaning to "output ready" and "input ready".

A half-full flag and two threshold flags complete the status set. The threshold flags are almost-empty and almost-full, and their offsets are programmable. While the load input is high, write-enabled write edges go to the offset registers instead of the memory, in a fixed alternating order. The output bus floats when the output enable is low.

Top module: `dsfifo`

## Requirements
- R1: After reset both pointers are zero, both offsets are 7, `almost_empty` is 1, and `almost_full` and `half_full` are 0. The output register holds zero.
- R2: A write-clock edge with `wen`=1, `load`=0 and the FIFO not full stores `din`. A write while full is dropped and does not disturb stored data. The write-side fill count never exceeds DEPTH.
- R3: In standard mode a stored word appears on `q` only after a read-clock edge with `ren`=1. `q` holds its value between reads.
- R4: In fall-through mode the oldest word appears on `q` with no `ren`. A read-clock edge with `ren`=1 replaces it with the next word. The ready indication drops only after such an edge.
- R5: `rd_stat` is 1 when empty in standard mode, and 1 when `q` holds a valid word in fall-through mode. `wr_stat` is 1 when full in standard mode, and 1 when not full in fall-through mode.
- R6: `half_full` is 1 exactly when the write-side fill count exceeds DEPTH/2. It is always 1 when full.
- R7: `almost_full` is 1 exactly when the write-side fill count is at least DEPTH minus the almost-full offset.
- R8: `almost_empty` is 1 exactly when the read-side count of words in memory is at most the almost-empty offset.
- R9: While `load`=1, each write-enabled write edge stores `din[AW-1:0]` into an offset register rather than the memory. The first such edge after reset writes the almost-empty offset, the next writes the almost-full offset, and the order then repeats.
- R10: With `oe`=0 the `q` pins float. Internal state and the output register are not affected.
- R11: In standard mode a read-enabled edge while empty changes neither `q` nor the read pointer.
- R12: Under unrelated clocks every word is read out once, in write order. The write pointer code sent across domains changes by at most one bit per write clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| mode_fwft | input | 1 | Read timing select, captured during reset (1 = fall-through) |
| wen | input | 1 | Write enable |
| load | input | 1 | Steers enabled writes to the offset registers |
| din | input | 18 | Write data or offset value |
| ren | input | 1 | Read enable or acknowledge |
| oe | input | 1 | Output drive enable |
| q | output | 18 | Read data, floating when `oe`=0 |
| rd_stat | output | 1 | Empty (standard) or output ready (fall-through) |
| wr_stat | output | 1 | Full (standard) or input ready (fall-through) |
| half_full | output | 1 | More than half of the depth is occupied |
| almost_empty | output | 1 | Stored count at or below the almost-empty offset |
| almost_full | output | 1 | Free space at or below the almost-full offset |

## Verification
The bench probes each threshold on both sides of its boundary: half-full at 128 and 129 words, almost-full at 248 and 249 words, and almost-empty at 8 and 7 words. A comparison off by one would flip one of these pairs. It then loads offsets of 20 and 30 and repeats the almost-empty and almost-full boundaries. A design that stored the offset words as data, or wrote the two registers in the wrong order, would move those boundaries.

The bench also writes while the FIFO is full and reads while it is empty. An overwrite would show up later in the read-back sequence, and a spurious pop would change `q`. In fall-through mode it checks that the first word arrives with no read enable and that status polarity flips. A design that reused standard-mode polarity would report empty as ready.

// File: rtl/dsfifo_pkg.sv
package dsfifo_pkg;
  typedef logic [15:0] ptr_t;

  function automatic ptr_t bin2gray(ptr_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic ptr_t gray2bin(ptr_t g);
    ptr_t b;
    b[15] = g[15];
    for (int i = 14; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // occupancy from two wrapped pointers of pw bits
  function automatic ptr_t fill_count(ptr_t a, ptr_t b, int unsigned pw);
    return (a - b) & ((ptr_t'(1) << pw) - ptr_t'(1));
  endfunction
endpackage

// File: rtl/dsfifo_sync.sv
module dsfifo_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/dsfifo_ram.sv
module dsfifo_ram #(
  parameter int DW = 18,
  parameter int AW = 8
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;
  logic [DW-1:0] mem [WORDS];
  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end
  assign rdata = mem[raddr];
endmodule

// File: rtl/dsfifo_wside.sv
module dsfifo_wside
  import dsfifo_pkg::*;
#(
  parameter int DW      = 18,
  parameter int DEPTH   = 256,
  parameter int AW      = 8,
  parameter int DEF_OFF = 7
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          mode_fwft,
  input  logic          wen,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic [AW:0]   rgray_s,
  output logic [AW:0]   wbin,
  output logic [AW:0]   wgray,
  output logic [AW:0]   wcount,
  output logic          push,
  output logic          full,
  output logic [AW-1:0] ae_off,
  output logic          wr_stat,
  output logic          half_full,
  output logic          almost_full
);
  localparam int PW = AW + 1;
  logic [PW-1:0] rbin_s;
  logic [AW-1:0] af_off;
  logic          sel_af;
  logic          fwft_w;
  logic          ld_hit;

  assign rbin_s    = PW'(gray2bin(ptr_t'(rgray_s)));
  assign wcount    = PW'(fill_count(ptr_t'(wbin), ptr_t'(rbin_s), PW));
  assign full      = (wcount == PW'(DEPTH));
  assign push      = wen & ~load & ~full;
  assign ld_hit    = wen & load;
  assign half_full = (wcount > PW'(DEPTH / 2));
  assign almost_full = (wcount >= (PW'(DEPTH) - PW'(af_off)));
  assign wr_stat   = fwft_w ? ~full : full;

  always_ff @(posedge wclk) begin
    if (!rst_n) fwft_w <= mode_fwft;
  end

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin   <= '0;
      wgray  <= '0;
      sel_af <= 1'b0;
      ae_off <= AW'(DEF_OFF);
      af_off <= AW'(DEF_OFF);
    end else begin
      if (push) begin
        wbin  <= wbin + 1'b1;
        wgray <= PW'(bin2gray(ptr_t'(wbin + 1'b1)));
      end
      if (ld_hit) begin
        if (sel_af) af_off <= din[AW-1:0];
        else        ae_off <= din[AW-1:0];
        sel_af <= ~sel_af;
      end
    end
  end
endmodule

// File: rtl/dsfifo_rside.sv
module dsfifo_rside
  import dsfifo_pkg::*;
#(
  parameter int DW = 18,
  parameter int AW = 8
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          mode_fwft,
  input  logic          ren,
  input  logic [AW:0]   wgray_s,
  input  logic [AW-1:0] ae_off,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rbin,
  output logic [AW:0]   rgray,
  output logic          mem_empty,
  output logic          pop,
  output logic          fwft_r,
  output logic [DW-1:0] dout,
  output logic          rd_stat,
  output logic          almost_empty
);
  localparam int PW = AW + 1;
  logic [PW-1:0] wbin_s, rcount;
  logic          valid;

  assign wbin_s       = PW'(gray2bin(ptr_t'(wgray_s)));
  assign rcount       = PW'(fill_count(ptr_t'(wbin_s), ptr_t'(rbin), PW));
  assign mem_empty    = (rcount == '0);
  assign almost_empty = (rcount <= PW'(ae_off));
  assign raddr        = rbin[AW-1:0];
  assign pop          = fwft_r ? (~mem_empty & (~valid | ren)) : (~mem_empty & ren);
  assign rd_stat      = fwft_r ? valid : mem_empty;

  always_ff @(posedge rclk) begin
    if (!rst_n) fwft_r <= mode_fwft;
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
      dout  <= '0;
      valid <= 1'b0;
    end else begin
      if (pop) begin
        rbin  <= rbin + 1'b1;
        rgray <= PW'(bin2gray(ptr_t'(rbin + 1'b1)));
        dout  <= rdata;
        valid <= 1'b1;
      end else if (ren) begin
        valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dsfifo.sv
module dsfifo #(
  parameter int DW    = 18,
  parameter int DEPTH = 256
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          mode_fwft,
  input  logic          wen,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic          ren,
  input  logic          oe,
  output wire  [DW-1:0] q,
  output logic          rd_stat,
  output logic          wr_stat,
  output logic          half_full,
  output logic          almost_empty,
  output logic          almost_full
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0] w_bin, w_gray, w_count, r_bin, r_gray, wgray_s, rgray_s;
  logic          w_push, w_full, r_pop, r_empty, r_fwft;
  logic [AW-1:0] ae_off, raddr;
  logic [DW-1:0] rdata, dout;

  dsfifo_wside #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .DEF_OFF(7)) u_wside (
    .wclk(wclk), .rst_n(rst_n), .mode_fwft(mode_fwft), .wen(wen), .load(load),
    .din(din), .rgray_s(rgray_s), .wbin(w_bin), .wgray(w_gray), .wcount(w_count),
    .push(w_push), .full(w_full), .ae_off(ae_off), .wr_stat(wr_stat),
    .half_full(half_full), .almost_full(almost_full)
  );

  dsfifo_sync #(.W(PW)) u_sync_w2r (.clk(rclk), .rst_n(rst_n), .d(w_gray), .q(wgray_s));
  dsfifo_sync #(.W(PW)) u_sync_r2w (.clk(wclk), .rst_n(rst_n), .d(r_gray), .q(rgray_s));

  dsfifo_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk(wclk), .we(w_push), .waddr(w_bin[AW-1:0]), .wdata(din),
    .raddr(raddr), .rdata(rdata)
  );

  dsfifo_rside #(.DW(DW), .AW(AW)) u_rside (
    .rclk(rclk), .rst_n(rst_n), .mode_fwft(mode_fwft), .ren(ren),
    .wgray_s(wgray_s), .ae_off(ae_off), .rdata(rdata), .raddr(raddr),
    .rbin(r_bin), .rgray(r_gray), .mem_empty(r_empty), .pop(r_pop),
    .fwft_r(r_fwft), .dout(dout), .rd_stat(rd_stat), .almost_empty(almost_empty)
  );

  assign q = oe ? dout : {DW{1'bz}};
endmodule

// File: rtl/dsfifo_chk.sv
module dsfifo_chk #(
  parameter int DEPTH = 256,
  parameter int PW    = 9
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst_n,
  input logic          ren,
  input logic          rd_stat,
  input logic          half_full,
  input logic          almost_full,
  input logic          w_full,
  input logic [PW-1:0] w_bin,
  input logic [PW-1:0] w_gray,
  input logic [PW-1:0] w_count,
  input logic          r_empty,
  input logic          r_fwft,
  input logic [PW-1:0] r_bin
);
  // R2
  full_hold_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    w_full |=> $stable(w_bin));
  // R2
  count_bound_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    w_count <= PW'(DEPTH));
  // R6
  half_at_full_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    w_full |-> half_full);
  // R7
  af_at_full_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    w_full |-> almost_full);
  // R11
  empty_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (!r_fwft && r_empty) |=> $stable(r_bin));
  // R4
  ready_drop_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (r_fwft && $fell(rd_stat)) |-> $past(ren));
  // R12
  gray_step_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    $countones(w_gray ^ $past(w_gray)) <= 1);
endmodule

bind dsfifo dsfifo_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .ren(ren), .rd_stat(rd_stat),
  .half_full(half_full), .almost_full(almost_full), .w_full(w_full),
  .w_bin(w_bin), .w_gray(w_gray), .w_count(w_count), .r_empty(r_empty),
  .r_fwft(r_fwft), .r_bin(r_bin)
);

// File: tb/sim_dsfifo.sv
module sim_dsfifo;
  localparam int CLK_PERIOD = 10;
  localparam int RCLK_PERIOD = 14;
  localparam int DEPTH = 256;
  localparam logic [17:0] VEC [8] = '{18'h00001, 18'h3FFFF, 18'h15555, 18'h2AAAA,
                                      18'h00100, 18'h12345, 18'h20000, 18'h0F0F0};

  logic wclk = 0, rclk = 0, rst_n = 0, mode_fwft = 0;
  logic wen = 0, load = 0, ren = 0, oe = 1;
  logic [17:0] din = '0;
  wire  [17:0] q;
  logic rd_stat, wr_stat, half_full, almost_empty, almost_full;
  int total = 0, bad = 0;
  bit done = 0;

  dsfifo #(.DW(18), .DEPTH(DEPTH)) u0 (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .mode_fwft(mode_fwft), .wen(wen),
    .load(load), .din(din), .ren(ren), .oe(oe), .q(q), .rd_stat(rd_stat),
    .wr_stat(wr_stat), .half_full(half_full), .almost_empty(almost_empty),
    .almost_full(almost_full)
  );

  always #(CLK_PERIOD/2) wclk = ~wclk;
  always #(RCLK_PERIOD/2) rclk = ~rclk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic m);
    rst_n = 0; mode_fwft = m; wen = 0; ren = 0; load = 0;
    repeat (4) @(posedge wclk);
    repeat (4) @(posedge rclk);
    #1 rst_n = 1;
  endtask

  task automatic wr(input logic [17:0] d);
    @(posedge wclk); #1 wen = 1; din = d;
    @(posedge wclk); #1 wen = 0;
  endtask

  task automatic rd();
    @(posedge rclk); #1 ren = 1;
    @(posedge rclk); #1 ren = 0;
  endtask

  task automatic settle();
    repeat (6) @(posedge rclk);
    repeat (6) @(posedge wclk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [17:0] last;
    // ---- standard mode, reset state
    do_reset(0);
    settle();
    chk("R1 rd_stat empty", rd_stat, 1);
    chk("R1 wr_stat", wr_stat, 0);
    chk("R1 almost_empty", almost_empty, 1);
    chk("R1 almost_full", almost_full, 0);
    chk("R1 half_full", half_full, 0);
    chk("R1 q", q, 0);
    // ---- vector table walk
    foreach (VEC[i]) wr(VEC[i]);
    settle();
    chk("R3 q before read", q, 0);
    chk("R5 not empty", rd_stat, 0);
    foreach (VEC[i]) begin
      rd();
      chk("R3 R12 read order", q, VEC[i]);
    end
    settle();
    chk("R5 empty after drain", rd_stat, 1);
    // ---- output enable
    oe = 0; #1;
    chk("R10 q floats", (q !== VEC[7]), 1);
    oe = 1; #1;
    chk("R10 q restored", q, VEC[7]);
    // ---- fill to full with threshold boundaries
    for (int i = 0; i < DEPTH; i++) begin
      wr(18'(i + 1000));
      if (i + 1 == 128) chk("R6 hf at 128", half_full, 0);
      if (i + 1 == 129) chk("R6 hf at 129", half_full, 1);
      if (i + 1 == 248) chk("R7 af at 248", almost_full, 0);
      if (i + 1 == 249) chk("R7 af at 249", almost_full, 1);
    end
    chk("R5 full", wr_stat, 1);
    wr(18'h3FFFF);
    chk("R2 still full", wr_stat, 1);
    settle();
    for (int k = 1; k <= DEPTH; k++) begin
      rd();
      if (q !== 18'(k - 1 + 1000)) chk("R2 R12 readback", q, 18'(k - 1 + 1000));
      if (k == 248) chk("R8 ae at 8 left", almost_empty, 0);
      if (k == 249) chk("R8 ae at 7 left", almost_empty, 1);
    end
    chk("R2 last word not overwritten", q, 18'(DEPTH - 1 + 1000));
    settle();
    last = q;
    rd();
    chk("R11 read on empty", q, last);
    // ---- offset loading
    @(posedge wclk); #1 load = 1;
    wr(18'd20);
    wr(18'd30);
    load = 0;
    for (int i = 0; i < 20; i++) wr(18'(i));
    settle();
    chk("R9 ae with 20 loaded", almost_empty, 1);
    wr(18'd99);
    settle();
    chk("R9 ae above 20", almost_empty, 0);
    for (int i = 0; i < 204; i++) wr(18'(i));
    chk("R9 R7 af at 225", almost_full, 0);
    wr(18'd5);
    chk("R9 R7 af at 226", almost_full, 1);
    // ---- fall-through mode
    do_reset(1);
    settle();
    chk("R1 R5 fwft rd_stat", rd_stat, 0);
    chk("R1 R5 fwft wr_stat", wr_stat, 1);
    wr(18'h01234);
    chk("R4 not yet ready", rd_stat, 0);
    settle();
    chk("R4 ready without ren", rd_stat, 1);
    chk("R4 first word", q, 18'h01234);
    wr(18'h00ABC);
    wr(18'h02DEF);
    settle();
    chk("R4 holds without ren", q, 18'h01234);
    rd();
    chk("R4 second word", q, 18'h00ABC);
    rd();
    chk("R4 third word", q, 18'h02DEF);
    rd();
    settle();
    chk("R5 fwft not ready", rd_stat, 0);
    wr(18'h00777);
    settle();
    for (int i = 0; i < DEPTH; i++) begin
      wr(18'(i));
      if (i + 1 == DEPTH - 1) chk("R5 input ready", wr_stat, 1);
    end
    chk("R5 input not ready", wr_stat, 0);
    chk("R4 head word", q, 18'h00777);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule